// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar in packed BCD registers: seconds, minutes, hours, day of week, date, month and a two-digit year. A divider chain runs on a fast reference clock and produces one tick per second. Each tick advances the seconds, and carries ripple up through the minutes, hours, day and date, month and year.

A register interface loads any field through a one-hot write strobe. All seven fields are always visible in parallel, so the interface can take a consistent snapshot of them. The hours field works in either a 12-hour or a 24-hour encoding. A halt bit in the seconds field freezes the clock. A 1 Hz square wave is phase-locked to the last seconds write.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the fields read seconds 00 (running), minutes 00, hours 00 in 24-hour mode, day 1, date 01, month 01 and year 00, and `sqw_out` is low.
- R2: Seconds and minutes count 00 to 59 in BCD. Seconds 59 rolls to 00 and advances the minutes. Minutes 59 rolls to 00 and advances the hours. One second lasts `TICKS_PER_SEC` clock cycles.
- R3: When seconds bit 7 (the halt bit) is 1, no field changes except through a write, and the divider is frozen. Writing it back to 0 resumes counting.
- R4: Hours bit 6 = 0 selects 24-hour mode, in which bits 5:4 hold the tens digit. Hours run 00 to 23, and 23 rolls to 00 and advances the day and the date.
- R5: Hours bit 6 = 1 selects 12-hour mode, in which bit 5 is PM and bit 4 is the tens digit. In this mode:
  - 11 goes to 12 and toggles PM.
  - 12 goes to 01 and leaves PM unchanged.
  - Only 11 PM to 12 AM advances the day and the date.
  - The mode bit itself is never changed by counting.
- R6: The day of week advances at midnight and wraps from 7 to 1.
- R7: A month has 31 days, except 04, 06, 09 and 11, which have 30, and 02, which has 28. February has 29 days when the year value is a multiple of 4.
- R8: A date past the last day of the month becomes 01 and advances the month. Month 12 becomes 01 and advances the year. Year 99 becomes 00.
- R9: A seconds write restarts the divider. After the write, the next second boundary falls exactly `TICKS_PER_SEC` cycles later. When `sqw_en` = 1, `sqw_out` is low for the first `TICKS_PER_SEC/2` cycles after the write and high for the rest of the second. When `sqw_en` = 0, `sqw_out` stays low.
- R10: `wr_stb` bit 0 writes seconds, and bits 1 to 6 write minutes, hours, day, date, month and year. Written bits outside each field read 0. The fields keep these bits:
  - seconds: 7:0
  - minutes: 6:0
  - hours: 6:0
  - day: 2:0
  - date: 5:0
  - month: 4:0
  - year: 7:0
- R11: Out-of-range values never lock up the counters. Minutes above 59 roll to 00 at the next carry, and day 0 becomes 1 at the next midnight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 7 | One-hot field write strobes |
| wr_data | input | 8 | Write data |
| sqw_en | input | 1 | Square-wave enable |
| sec_q | output | 8 | Halt bit and BCD seconds |
| min_q | output | 8 | BCD minutes |
| hour_q | output | 8 | Mode, PM or tens, and BCD hours |
| day_q | output | 8 | Day of week |
| date_q | output | 8 | BCD date |
| mon_q | output | 8 | BCD month |
| year_q | output | 8 | BCD year |
| sqw_out | output | 1 | 1 Hz square wave |

## Verification
A divider that is out of phase shows up on `sqw_out` within half a second of a seconds write, and in the seconds field one second after it. A wrong rollover limit or carry condition stays hidden until its own field rolls over. For that reason the bench loads each field just short of its boundary and checks after a single tick:
- every hour value in both modes
- both the last and the second-to-last day of every month of all hundred years

It also lets the clock run freely through a full hour.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] wr_stb,
  input  logic [7:0] wr_data,
  input  logic       sqw_en,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] day_q,
  output logic [7:0] date_q,
  output logic [7:0] mon_q,
  output logic [7:0] year_q,
  output logic       sqw_out
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF = CW'(TICKS_PER_SEC / 2);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  logic [CW-1:0] cnt;
  logic halt, tick;
  assign halt = sec_q[7];
  assign tick = !halt && (cnt == LAST) && !wr_stb[0];
  assign sqw_out = sqw_en && (cnt >= HALF);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (wr_stb[0]) cnt <= '0;
    else if (tick)      cnt <= '0;
    else if (!halt)     cnt <= cnt + 1'b1;
  end

  logic sec_wrap, min_wrap, hour_day, date_wrap, mon_wrap, year_wrap, leap;
  logic [7:0] sec_nx, min_nx, hour_nx, day_nx, date_nx, mon_nx, year_nx;
  logic [7:0] last_date, ybin;

  assign sec_wrap = sec_q[6:0] >= 7'h59;
  assign sec_nx   = sec_wrap ? {sec_q[7], 7'h00} : bcd_inc(sec_q);
  assign min_wrap = min_q >= 8'h59;
  assign min_nx   = min_wrap ? 8'h00 : bcd_inc(min_q);

  always_comb begin
    hour_day = 1'b0;
    hour_nx  = bcd_inc(hour_q);
    if (hour_q[6]) begin
      if (hour_q[4:0] == 5'h11) begin
        hour_nx  = {2'b01, ~hour_q[5], 5'h12};
        hour_day = hour_q[5];
      end else if (hour_q[4:0] >= 5'h12) begin
        hour_nx = {2'b01, hour_q[5], 5'h01};
      end
    end else if (hour_q[5:0] >= 6'h23) begin
      hour_nx  = 8'h00;
      hour_day = 1'b1;
    end
  end

  assign day_nx = (day_q == 8'h00 || day_q >= 8'h07) ? 8'h01 : day_q + 8'd1;

  assign ybin = {4'b0, year_q[7:4]} * 8'd10 + {4'b0, year_q[3:0]};
  assign leap = (ybin[1:0] == 2'b00);

  always_comb begin
    case (mon_q)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end

  assign date_wrap = date_q >= last_date;
  assign date_nx   = date_wrap ? 8'h01 : bcd_inc(date_q);
  assign mon_wrap  = mon_q >= 8'h12;
  assign mon_nx    = mon_wrap ? 8'h01 : bcd_inc(mon_q);
  assign year_wrap = year_q >= 8'h99;
  assign year_nx   = year_wrap ? 8'h00 : bcd_inc(year_q);

  logic c_min, c_hour, c_day, c_mon, c_year;
  assign c_min  = tick && sec_wrap;
  assign c_hour = c_min && min_wrap;
  assign c_day  = c_hour && hour_day;
  assign c_mon  = c_day && date_wrap;
  assign c_year = c_mon && mon_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      day_q  <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else begin
      if (wr_stb[0])   sec_q  <= wr_data;
      else if (tick)   sec_q  <= sec_nx;
      if (wr_stb[1])   min_q  <= wr_data & 8'h7F;
      else if (c_min)  min_q  <= min_nx;
      if (wr_stb[2])   hour_q <= wr_data & 8'h7F;
      else if (c_hour) hour_q <= hour_nx;
      if (wr_stb[3])   day_q  <= wr_data & 8'h07;
      else if (c_day)  day_q  <= day_nx;
      if (wr_stb[4])   date_q <= wr_data & 8'h3F;
      else if (c_day)  date_q <= date_nx;
      if (wr_stb[5])   mon_q  <= wr_data & 8'h1F;
      else if (c_mon)  mon_q  <= mon_nx;
      if (wr_stb[6])   year_q <= wr_data;
      else if (c_year) year_q <= year_nx;
    end
  end

  p_halt_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && wr_stb == 7'd0) |=> $stable({sec_q, min_q, hour_q, day_q, date_q, mon_q, year_q}));

  p_sec_write_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[0] |=> !sqw_out);

  p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[6:0] <= 7'h59 && sec_q[3:0] <= 4'd9 && !wr_stb[0]) |=> (sec_q[6:0] <= 7'h59));

  p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb[1] && !c_min) |=> $stable(min_q));

  p_day_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (day_q >= 8'h01 && day_q <= 8'h07 && !wr_stb[3]) |=> (day_q >= 8'h01 && day_q <= 8'h07));

  p_mode_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb[2] |=> (hour_q[6] == $past(hour_q[6])));
endmodule

// File: tb/bcd_rtc_bench.sv
module bcd_rtc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;

  logic clk = 1'b0, rst_n = 1'b0, sqw_en = 1'b0;
  logic [6:0] wr_stb = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_q, min_q, hour_q, day_q, date_q, mon_q, year_q;
  logic sqw_out;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(TPS)) u_bcd_rtc (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .sqw_en(sqw_en),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .day_q(day_q), .date_q(date_q),
    .mon_q(mon_q), .year_q(year_q), .sqw_out(sqw_out));

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] val);
    @(negedge clk);
    wr_stb = 7'(1 << idx);
    wr_data = val;
    @(negedge clk);
    wr_stb = '0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, y);
    wr(0, 8'h80);
    wr(1, m); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
    wr(0, s);
  endtask

  task automatic wait_sec();
    repeat (TPS) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 sec", sec_q, 8'h00);   chk("R1 min", min_q, 8'h00);
    chk("R1 hour", hour_q, 8'h00); chk("R1 day", day_q, 8'h01);
    chk("R1 date", date_q, 8'h01); chk("R1 mon", mon_q, 8'h01);
    chk("R1 year", year_q, 8'h00); chk("R1 sqw", 8'(sqw_out), 8'h00);

    // R10 masks of write data
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF);
    wr(4, 8'hFF); wr(5, 8'hFF); wr(6, 8'hFF);
    chk("R10 sec", sec_q, 8'hFF);   chk("R10 min", min_q, 8'h7F);
    chk("R10 hour", hour_q, 8'h7F); chk("R10 day", day_q, 8'h07);
    chk("R10 date", date_q, 8'h3F); chk("R10 mon", mon_q, 8'h1F);
    chk("R10 year", year_q, 8'hFF);

    // R3 halt freezes, release resumes
    wr(0, 8'hB0);
    repeat (20) @(negedge clk);
    chk("R3 halted sec", sec_q, 8'hB0);
    chk("R3 halted min", min_q, 8'h7F);
    wr(0, 8'h30);
    wait_sec();
    chk("R3 resumed sec", sec_q, 8'h31);

    // R9 divider restart and square-wave phase
    sqw_en = 1'b1;
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    for (int c = 0; c < TPS; c++) begin
      chk("R9 sqw phase", 8'(sqw_out), (c >= TPS/2) ? 8'h01 : 8'h00);
      chk("R9 sec held", sec_q, 8'h10);
      @(negedge clk);
    end
    chk("R9 sec tick", sec_q, 8'h11);
    chk("R9 sqw low at tick", 8'(sqw_out), 8'h00);
    sqw_en = 1'b0;
    for (int c = 0; c < TPS; c++) begin
      @(negedge clk);
      chk("R9 sqw disabled", 8'(sqw_out), 8'h00);
    end

    // R2 free run through one hour
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    for (int i = 1; i <= 3600; i++) begin
      wait_sec();
      chk("R2 sec", sec_q, bcd(i % 60));
      chk("R2 min", min_q, bcd((i / 60) % 60));
      chk("R2 hour", hour_q, bcd(i / 3600));
    end

    // R4 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      set_time(8'h59, 8'h59, bcd(h), 8'h05, 8'h10, 8'h06, 8'h21);
      wait_sec();
      chk("R4 hour", hour_q, bcd((h + 1) % 24));
      chk("R4 min", min_q, 8'h00);
      chk("R6 day", day_q, (h == 23) ? 8'h06 : 8'h05);
      chk("R4 date", date_q, (h == 23) ? 8'h11 : 8'h10);
    end

    // R5 12-hour sweep
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        automatic int nh = (h == 12) ? 1 : h + 1;
        automatic int npm = (h == 11) ? 1 - pm : pm;
        automatic bit dc = (h == 11) && (pm == 1);
        set_time(8'h59, 8'h59, 8'h40 | 8'(pm << 5) | bcd(h), 8'h02, 8'h10, 8'h06, 8'h21);
        wait_sec();
        chk("R5 hour", hour_q, 8'h40 | 8'(npm << 5) | bcd(nh));
        chk("R5 day", day_q, dc ? 8'h03 : 8'h02);
        chk("R5 date", date_q, dc ? 8'h11 : 8'h10);
      end
    end

    // R6 day wrap 7 -> 1
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h05, 8'h03, 8'h10);
    wait_sec();
    chk("R6 day wrap", day_q, 8'h01);

    // R7 and R8 month-end sweep over all years
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        automatic int L = days_in(m, y);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, bcd(L - 1), bcd(m), bcd(y));
        wait_sec();
        chk("R7 last day reached", date_q, bcd(L));
        chk("R7 month held", mon_q, bcd(m));
        set_time(8'h59, 8'h59, 8'h23, 8'h03, bcd(L), bcd(m), bcd(y));
        wait_sec();
        chk("R8 date wrap", date_q, 8'h01);
        chk("R8 month", mon_q, bcd(m % 12 + 1));
        chk("R8 year", year_q, bcd((m == 12) ? (y + 1) % 100 : y));
      end
    end

    // R11 out-of-range recovery
    set_time(8'h59, 8'h7F, 8'h05, 8'h02, 8'h10, 8'h06, 8'h21);
    wait_sec();
    chk("R11 min recover", min_q, 8'h00);
    chk("R11 hour carry", hour_q, 8'h06);
    set_time(8'h59, 8'h59, 8'h23, 8'h00, 8'h10, 8'h06, 8'h21);
    wait_sec();
    chk("R11 day recover", day_q, 8'h01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule